// File: doc/BRIEF.md
# RAM-Programmable Address Decoder

This block decodes a processor address into a set of active-low select lines, taking the select pattern for each address region from a writable table instead of fixed logic. The table is indexed by the top `IDX_W` bits of the address. Each entry is `ENTRY_W` bits wide and holds one active-low select per bit.

After reset the block is in the program state (`ST_PROG`). In this state, processor reads are steered to the boot ROM. Every processor write lands in the table at the entry named by the written address, and a write is only taken while phi2 is high. Peripherals stay deselected throughout.

A loader running from the boot ROM fills the table and then raises the mode-switch input. The block then enters the run state (`ST_RUN`). In this state the entry for the current address drives the select lines directly. Bit `ROM_BIT` of that entry takes over the boot ROM select, so the loader's own region can be remapped. The table is cut off from the data bus, and the peripheral write strobe is phi2 high with R/W low.

If the switch request arrives while phi2 is high, the block waits in an arming state (`ST_ARM`) until phi2 falls. This keeps a write cycle from being cut in half. The switch is one-way until reset.

The named transitions are:
- `ST_PROG` to `ST_RUN` on a request while phi2 is low.
- `ST_PROG` to `ST_ARM` on a request while phi2 is high.
- `ST_ARM` to `ST_RUN` once phi2 is sampled low.
- `ST_RUN` to `ST_RUN` always.

Top module: `rpd_decoder`

## Requirements
- R1: After reset the state is `ST_PROG`, every `map_cs_n` bit is 1, `wr_strobe_n` is 1, and every table entry reads back as all ones once in run mode.
- R2: In `ST_PROG` and `ST_ARM`, `boot_cs_n` is 0 when `cpu_rw` is 1 (read) and 1 when `cpu_rw` is 0, and `map_cs_n` is all ones.
- R3: In `ST_PROG`, a clock edge with `phi2`=1 and `cpu_rw`=0 stores `cpu_wdata` in the entry indexed by `cpu_addr[ADDR_W-1 -: IDX_W]`. A write with `phi2`=0 stores nothing.
- R4: A clock edge in `ST_PROG` with `go_run`=1 moves to `ST_RUN` if `phi2`=0, or to `ST_ARM` if `phi2`=1. `ST_ARM` moves to `ST_RUN` on the first edge with `phi2`=0.
- R5: In `ST_RUN`, `map_cs_n` equals the table entry indexed by the current address, combinationally.
- R6: In `ST_RUN`, `boot_cs_n` equals bit `ROM_BIT` (default 7) of the current entry.
- R7: In `ST_RUN`, the table ignores the data bus: bus writes change no entry.
- R8: `ST_RUN` is left only by reset. `go_run` has no further effect.
- R9: `wr_strobe_n` is 0 only in `ST_RUN` with `phi2`=1 and `cpu_rw`=0.
- R10: In `ST_ARM`, writes with `phi2`=1 still land in the table as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | ENTRY_W | Processor write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Processor phase-2 clock level |
| go_run | input | 1 | Request to switch to run mode |
| map_cs_n | output | ENTRY_W | Active-low selects from the table |
| boot_cs_n | output | 1 | Active-low boot ROM select |
| wr_strobe_n | output | 1 | Active-low peripheral write strobe |

## Verification
The bench builds the block with `IDX_W`=4 and `ADDR_W`=16, keeping the default 8-bit entries and `ROM_BIT`=7. With these values all sixteen entries can be written and then read back by sweeping the address, including an entry whose ROM bit is low. Separate resets exercise both switch paths: the direct switch with phi2 low, and the armed switch with phi2 high. The armed path includes a write that lands while the block is waiting.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
    typedef enum logic [1:0] {
        ST_PROG = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } dec_state_e;
endpackage

// File: rtl/rpd_map_table.sv
module rpd_map_table #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [ENTRY_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rpd_mode_fsm.sv
module rpd_mode_fsm
    import rpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_run,
    input  logic       phi2,
    output dec_state_e state,
    output logic       prog_mode
);
    dec_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PROG;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        prog_mode = 1'b1;
        unique case (state)
            ST_PROG: begin
                if (go_run) state_nx = phi2 ? ST_ARM : ST_RUN;
            end
            ST_ARM: begin
                if (!phi2) state_nx = ST_RUN;
            end
            ST_RUN: begin
                prog_mode = 1'b0;
            end
            default: begin
                state_nx = ST_PROG;
            end
        endcase
    end

    // R8: run state is held until reset
    a_r8_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN));
    // R4: armed switch completes on first phi2-low edge
    a_r4_arm_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && !phi2) |=> (state == ST_RUN));
    // R4: request during phi2 high never jumps straight to run
    a_r4_no_direct_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && go_run && phi2) |=> (state == ST_ARM));
endmodule

// File: rtl/rpd_decoder.sv
module rpd_decoder
    import rpd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 8,
    parameter int ROM_BIT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [ENTRY_W-1:0] cpu_wdata,
    input  logic               cpu_rw,
    input  logic               phi2,
    input  logic               go_run,
    output logic [ENTRY_W-1:0] map_cs_n,
    output logic               boot_cs_n,
    output logic               wr_strobe_n
);
    localparam int IDX_LSB = ADDR_W - IDX_W;

    dec_state_e         state;
    logic               prog_mode;
    logic [IDX_W-1:0]   idx;
    logic               tbl_we;
    logic [ENTRY_W-1:0] tbl_din;
    logic [ENTRY_W-1:0] tbl_word;

    assign idx     = cpu_addr[ADDR_W-1:IDX_LSB];
    assign tbl_we  = prog_mode & phi2 & ~cpu_rw;
    // separating buffer: data bus reaches the table only while programming
    assign tbl_din = prog_mode ? cpu_wdata : '0;

    rpd_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_run    (go_run),
        .phi2      (phi2),
        .state     (state),
        .prog_mode (prog_mode)
    );

    rpd_map_table #(
        .IDX_W   (IDX_W),
        .ENTRY_W (ENTRY_W)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (idx),
        .wdata (tbl_din),
        .raddr (idx),
        .rdata (tbl_word)
    );

    always_comb begin
        map_cs_n    = '1;
        boot_cs_n   = 1'b1;
        wr_strobe_n = 1'b1;
        unique case (state)
            ST_PROG, ST_ARM: begin
                boot_cs_n = ~cpu_rw;
            end
            ST_RUN: begin
                map_cs_n    = tbl_word;
                boot_cs_n   = tbl_word[ROM_BIT];
                wr_strobe_n = ~(phi2 & ~cpu_rw);
            end
            default: begin
                map_cs_n = '1;
            end
        endcase
    end

    // R7: no table write while running
    a_r7_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> !tbl_we);
    // R9: strobe only in run mode with phi2 high and a write
    a_r9_strobe_qual: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe_n |-> (state == ST_RUN && phi2 && !cpu_rw));
    // R2: peripherals deselected while programming
    a_r2_prog_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> (map_cs_n == '1));
    // R6: ROM select follows its table bit in run mode
    a_r6_rom_from_table: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (boot_cs_n == map_cs_n[ROM_BIT]));
endmodule

// File: tb/rpd_decoder_bench.sv
module rpd_decoder_bench;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 4;
    localparam int N      = 1 << IDX_W;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_rw = 1;
    logic              phi2 = 0;
    logic              go_run = 0;
    logic [7:0]        map_cs_n;
    logic              boot_cs_n;
    logic              wr_strobe_n;

    int   n_run = 0;
    int   n_fail = 0;
    logic [7:0] model [N];

    always #5 clk = ~clk;

    rpd_decoder #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENTRY_W(8), .ROM_BIT(7)) u_rpd_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rw(cpu_rw), .phi2(phi2), .go_run(go_run),
        .map_cs_n(map_cs_n), .boot_cs_n(boot_cs_n), .wr_strobe_n(wr_strobe_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] addr_of(input int i);
        return {i[IDX_W-1:0], 12'h0ab};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; go_run = 0; phi2 = 0; cpu_rw = 1;
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < N; i++) model[i] = 8'hFF;
    endtask

    // one bus write: phi2 high over one clock edge
    task automatic cpu_write(input int i, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = addr_of(i); cpu_wdata = d; cpu_rw = 0; phi2 = 1;
        @(negedge clk);
        phi2 = 0; cpu_rw = 1;
    endtask

    task automatic t_reset_and_direct_switch();
        do_reset();
        #1;
        check("R1 cs after reset", map_cs_n, 8'hFF);
        check("R1 strobe after reset", {7'd0, wr_strobe_n}, 8'd1);
        check("R2 rom on read", {7'd0, boot_cs_n}, 8'd0);
        cpu_rw = 0; #1;
        check("R2 rom off on write", {7'd0, boot_cs_n}, 8'd1);
        cpu_rw = 1;
        @(negedge clk);
        go_run = 1; phi2 = 0; cpu_addr = addr_of(9); #1;
        check("R4 still prog before edge", map_cs_n, 8'hFF);
        check("R2 rom before edge", {7'd0, boot_cs_n}, 8'd0);
        @(negedge clk);
        go_run = 0; #1;
        check("R4 direct run: rom from entry", {7'd0, boot_cs_n}, 8'd1);
        check("R1 reset entry all ones", map_cs_n, 8'hFF);
    endtask

    task automatic t_program_and_armed_switch();
        do_reset();
        for (int i = 0; i < N; i++) begin
            logic [7:0] v = 8'hFF ^ (8'h01 << (i % 8));
            if (i == 15) v = 8'h7F;
            cpu_write(i, v);
            model[i] = v;
            #1;
            check("R2 no select while programming", map_cs_n, 8'hFF);
        end
        // phi2-low write is ignored (R3)
        @(negedge clk);
        cpu_addr = addr_of(3); cpu_wdata = 8'h00; cpu_rw = 0; phi2 = 0;
        #1;
        check("R9 no strobe in prog", {7'd0, wr_strobe_n}, 8'd1);
        @(negedge clk);
        cpu_rw = 1;
        // armed switch with a write pending (R4, R10)
        @(negedge clk);
        cpu_addr = addr_of(5); cpu_wdata = 8'hA5; cpu_rw = 0; phi2 = 1; go_run = 1;
        @(negedge clk);
        go_run = 0; cpu_wdata = 8'h5A;
        @(negedge clk);
        model[5] = 8'h5A;
        phi2 = 0; cpu_rw = 1; cpu_addr = addr_of(2); #1;
        check("R4 armed not yet running", map_cs_n, 8'hFF);
        check("R2 rom in arm state", {7'd0, boot_cs_n}, 8'd0);
        @(negedge clk); #1;
        check("R4 running after phi2 low", map_cs_n, model[2]);
        for (int i = 0; i < N; i++) begin
            cpu_addr = addr_of(i); #1;
            check("R5 entry drives selects", map_cs_n, model[i]);
            check("R6 rom bit", {7'd0, boot_cs_n}, {7'd0, model[i][7]});
        end
        cpu_addr = addr_of(3); #1;
        check("R3 phi2-low write dropped", map_cs_n, model[3]);
        cpu_addr = addr_of(5); #1;
        check("R10 write in arm state landed", map_cs_n, 8'h5A);
    endtask

    task automatic t_run_mode_bus();
        @(negedge clk);
        cpu_addr = addr_of(1); cpu_wdata = 8'h00; cpu_rw = 0; phi2 = 1; #1;
        check("R9 strobe on run write", {7'd0, wr_strobe_n}, 8'd0);
        @(negedge clk);
        cpu_rw = 1; #1;
        check("R9 no strobe on read", {7'd0, wr_strobe_n}, 8'd1);
        phi2 = 0; cpu_rw = 0; #1;
        check("R9 no strobe phi2 low", {7'd0, wr_strobe_n}, 8'd1);
        cpu_rw = 1;
        @(negedge clk); #1;
        check("R7 run write ignored", map_cs_n, model[1]);
        go_run = 1;
        @(negedge clk);
        go_run = 0;
        @(negedge clk);
        cpu_addr = addr_of(7); #1;
        check("R8 still running", map_cs_n, model[7]);
        check("R8 rom from entry", {7'd0, boot_cs_n}, 8'd0);
    endtask

    initial begin
        t_reset_and_direct_switch();
        t_program_and_armed_switch();
        t_run_mode_bus();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule